// File: doc/BRIEF.md
# Context and Upper Delegation CSR Access Gate

This block decides, in a single combinational step, whether an instruction may touch one of three hypervisor-related control registers: the supervisor context register, the hypervisor context register, and the upper half of the hypervisor exception-delegation register. From the register address, the current privilege level, the virtualization flag, the native register width, and the machine-level and hypervisor-level state-enable words, it returns one of three verdicts. The access is allowed, it raises an illegal-instruction exception, or it raises a virtual-instruction exception.

The gating works in layers. A width check on the upper delegation half comes first. The state-enable gates come next, and each register uses its own enable bit at its own level. The generic privilege check taken from the address runs last. For any other address only the generic check applies. The block also reports the mask of bits that the selected register implements, which depends on the native width and on whether the hypervisor extension is present. The CSR file can use this mask without repeating the width rules.

Top module: `ctx_stateen_gate`

## Requirements
- R1: The verdict output is purely combinational and encoded as 2'b00 allow, 2'b01 illegal-instruction, 2'b10 virtual-instruction. The value 2'b11 never appears.
- R2: Any access to address 0x612 when `xlen_is32` is low is illegal-instruction. This holds at every privilege level and takes priority over every state-enable check.
- R3: Below machine mode, with `stateen_present` high, an access to 0x612 with bit 56 of `mstateen0` clear is illegal-instruction.
- R4: Below machine mode, with `stateen_present` high, an access to 0x5A8 or 0x6A8 with bit 57 of `mstateen0` clear is illegal-instruction.
- R5: With `virt_mode` high, `stateen_present` high and R4 satisfied, an access to 0x5A8 with bit 57 of `hstateen0` clear is virtual-instruction.
- R6: Bit 57 of `hstateen0` has no effect on the verdict for 0x6A8.
- R7: With `stateen_present` low, neither state-enable word affects any verdict. Only R2 and R8 apply.
- R8: The generic check uses address bits [9:8] as the required level, with privilege encoded as U=0, S=1, M=3. Machine mode is always allowed. Level 3 below machine mode is illegal. Level 2 is virtual when virtualized, allowed from non-virtual S, and illegal from non-virtual U. Level 1 is allowed from S, virtual from VU, and illegal from U. Level 0 is always allowed.
- R9: In machine mode the state-enable words have no effect. Only R2 can deny access.
- R10: `impl_mask` is all ones over 16 bits for 0x5A8 when 32-bit and over 32 bits otherwise. For 0x6A8 it is all ones over 6 bits (32-bit) or 13 bits (64-bit), plus one more bit when `hyp_ext` is high. It is zero for 0x612 and for every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr | input | 12 | Address of the accessed register |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| virt_mode | input | 1 | Hart is running virtualized |
| xlen_is32 | input | 1 | Native register width is 32 bits |
| hyp_ext | input | 1 | Hypervisor extension present |
| stateen_present | input | 1 | State-enable mechanism implemented |
| mstateen0 | input | 64 | Machine-level state-enable word 0 |
| hstateen0 | input | 64 | Hypervisor-level state-enable word 0 |
| verdict | output | 2 | Access verdict as encoded in R1 |
| impl_mask | output | 32 | Implemented-bit mask of the selected register |

## Verification
The hardest case to reach is a virtualized access to the supervisor context register where only the hypervisor-level bit is clear. This case needs the machine-level bit set, state-enable present and a non-machine privilege all at once, and only then does the virtual-instruction verdict of R5 show. A second hard case is a 64-bit access to 0x612 in which every state-enable bit is also clear, because that is the only way to show that the width check wins over the state-enable check. The stimulus sweeps every combination of address, privilege, virtualization, width, extension flags and the three enable bits. Each point is compared against a behavioural model, so all of these cases are covered together with their neighbours.

// File: rtl/ctx_gate_pkg.sv
package ctx_gate_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    VERD_ALLOW   = 2'b00,
    VERD_ILLEGAL = 2'b01,
    VERD_VIRTUAL = 2'b10
  } verdict_e;

  typedef struct packed {
    logic sctx;
    logic hctx;
    logic delegh;
  } reg_sel_t;

endpackage

// File: rtl/ctx_gate_decode.sv
module ctx_gate_decode
  import ctx_gate_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter logic [11:0] SCTX_ADDR   = 12'h5A8,
  parameter logic [11:0] HCTX_ADDR   = 12'h6A8,
  parameter logic [11:0] DELEGH_ADDR = 12'h612
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel,
  output priv_e             req_level
);
  always_comb begin
    sel.sctx   = (addr == ADDR_W'(SCTX_ADDR));
    sel.hctx   = (addr == ADDR_W'(HCTX_ADDR));
    sel.delegh = (addr == ADDR_W'(DELEGH_ADDR));
    req_level  = priv_e'(addr[9:8]);
  end
endmodule

// File: rtl/ctx_gate_stateen.sv
module ctx_gate_stateen
  import ctx_gate_pkg::*;
#(
  parameter int SE_W        = 64,
  parameter int M_DELEG_BIT = 56,
  parameter int M_CTX_BIT   = 57,
  parameter int H_SCTX_BIT  = 57
) (
  input  reg_sel_t        sel,
  input  priv_e           priv,
  input  logic            virt,
  input  logic            present,
  input  logic [SE_W-1:0] m_word,
  input  logic [SE_W-1:0] h_word,
  output logic            deny_ill,
  output logic            deny_virt
);
  logic below_m;
  logic m_deleg_ok;
  logic m_ctx_ok;
  logic h_sctx_ok;

  always_comb begin
    below_m    = (priv != PRIV_M);
    m_deleg_ok = m_word[M_DELEG_BIT];
    m_ctx_ok   = m_word[M_CTX_BIT];
    h_sctx_ok  = h_word[H_SCTX_BIT];
    deny_ill   = 1'b0;
    deny_virt  = 1'b0;
    if (present && below_m) begin
      if (sel.delegh && !m_deleg_ok)
        deny_ill = 1'b1;
      else if ((sel.sctx || sel.hctx) && !m_ctx_ok)
        deny_ill = 1'b1;
      else if (virt && sel.sctx && !h_sctx_ok)
        deny_virt = 1'b1;
    end
  end
endmodule

// File: rtl/ctx_gate_priv.sv
module ctx_gate_priv
  import ctx_gate_pkg::*;
(
  input  priv_e    priv,
  input  logic     virt,
  input  priv_e    req_level,
  output verdict_e result
);
  always_comb begin
    result = VERD_ALLOW;
    if (priv != PRIV_M) begin
      unique case (req_level)
        PRIV_M: result = VERD_ILLEGAL;
        PRIV_H: begin
          if (virt)                 result = VERD_VIRTUAL;
          else if (priv != PRIV_S)  result = VERD_ILLEGAL;
        end
        PRIV_S: begin
          if (priv == PRIV_U) result = virt ? VERD_VIRTUAL : VERD_ILLEGAL;
        end
        default: result = VERD_ALLOW;
      endcase
    end
  end
endmodule

// File: rtl/ctx_stateen_gate.sv
module ctx_stateen_gate
  import ctx_gate_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int SE_W         = 64,
  parameter int MASK_W       = 32,
  parameter int SCTX_W32     = 16,
  parameter int SCTX_W64     = 32,
  parameter int HCTX_W32     = 6,
  parameter int HCTX_W64     = 13,
  parameter int M_DELEG_BIT  = 56,
  parameter int M_CTX_BIT    = 57,
  parameter int H_SCTX_BIT   = 57
) (
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [1:0]        cur_priv,
  input  logic              virt_mode,
  input  logic              xlen_is32,
  input  logic              hyp_ext,
  input  logic              stateen_present,
  input  logic [SE_W-1:0]   mstateen0,
  input  logic [SE_W-1:0]   hstateen0,
  output logic [1:0]        verdict,
  output logic [MASK_W-1:0] impl_mask
);
  localparam int HCTX_MAXW = HCTX_W64 + 1;

  reg_sel_t sel;
  priv_e    req_level;
  priv_e    priv;
  logic     se_ill;
  logic     se_virt;
  verdict_e gen_verdict;
  verdict_e final_verdict;
  logic     width_fault;
  int       hctx_w;
  int       sctx_w;

  assign priv = priv_e'(cur_priv);

  ctx_gate_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr      (csr_addr),
    .sel       (sel),
    .req_level (req_level)
  );

  ctx_gate_stateen #(
    .SE_W       (SE_W),
    .M_DELEG_BIT(M_DELEG_BIT),
    .M_CTX_BIT  (M_CTX_BIT),
    .H_SCTX_BIT (H_SCTX_BIT)
  ) u_stateen (
    .sel       (sel),
    .priv      (priv),
    .virt      (virt_mode),
    .present   (stateen_present),
    .m_word    (mstateen0),
    .h_word    (hstateen0),
    .deny_ill  (se_ill),
    .deny_virt (se_virt)
  );

  ctx_gate_priv u_priv (
    .priv      (priv),
    .virt      (virt_mode),
    .req_level (req_level),
    .result    (gen_verdict)
  );

  // Priority: width fault, then state-enable, then generic privilege.
  always_comb begin
    width_fault = sel.delegh && !xlen_is32;
    if (width_fault)   final_verdict = VERD_ILLEGAL;
    else if (se_ill)   final_verdict = VERD_ILLEGAL;
    else if (se_virt)  final_verdict = VERD_VIRTUAL;
    else               final_verdict = gen_verdict;
  end

  assign verdict = final_verdict;

  // Implemented-bit masks follow native width and hypervisor presence.
  always_comb begin
    sctx_w    = xlen_is32 ? SCTX_W32 : SCTX_W64;
    hctx_w    = (xlen_is32 ? HCTX_W32 : HCTX_W64) + (hyp_ext ? 1 : 0);
    impl_mask = '0;
    for (int i = 0; i < MASK_W; i++) begin
      if (sel.sctx && i < sctx_w) impl_mask[i] = 1'b1;
      if (sel.hctx && i < hctx_w && i < HCTX_MAXW) impl_mask[i] = 1'b1;
    end
  end

  always_comb begin
    assert_code_legal_R1: assert (verdict != 2'b11);
    assert_width_first_R2: assert (!(sel.delegh && !xlen_is32) || verdict == VERD_ILLEGAL);
    assert_machine_free_R9: assert (!(priv == PRIV_M && !(sel.delegh && !xlen_is32))
                                    || verdict == VERD_ALLOW);
    assert_absent_generic_R7: assert (stateen_present || (sel.delegh && !xlen_is32)
                                      || verdict == gen_verdict);
    assert_hctx_no_virtual_gate_R6: assert (!(sel.hctx && se_virt));
    assert_deleg_no_mask_R10: assert (!sel.delegh || impl_mask == '0);
  end
endmodule

// File: tb/tb_ctx_stateen_gate.sv
module tb_ctx_stateen_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr;
  logic [1:0]  cur_priv;
  logic        virt_mode, xlen_is32, hyp_ext, stateen_present;
  logic [63:0] mstateen0, hstateen0;
  logic [1:0]  verdict;
  logic [31:0] impl_mask;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctx_stateen_gate dut (
    .csr_addr(csr_addr), .cur_priv(cur_priv), .virt_mode(virt_mode),
    .xlen_is32(xlen_is32), .hyp_ext(hyp_ext), .stateen_present(stateen_present),
    .mstateen0(mstateen0), .hstateen0(hstateen0),
    .verdict(verdict), .impl_mask(impl_mask)
  );

  task automatic model(output logic [1:0] vd, output logic [31:0] mk, output string tag);
    bit sc, hc, dh;
    int w;
    sc = (csr_addr == 12'h5A8);
    hc = (csr_addr == 12'h6A8);
    dh = (csr_addr == 12'h612);
    mk = 32'h0;
    if (sc) mk = xlen_is32 ? 32'h0000FFFF : 32'hFFFFFFFF;
    if (hc) begin
      w = (xlen_is32 ? 6 : 13) + (hyp_ext ? 1 : 0);
      mk = (32'h1 << w) - 32'h1;
    end
    if (dh && !xlen_is32) begin vd = 2'b01; tag = "R2"; end
    else if (stateen_present && cur_priv != 2'd3 && dh && !mstateen0[56]) begin vd = 2'b01; tag = "R3"; end
    else if (stateen_present && cur_priv != 2'd3 && (sc || hc) && !mstateen0[57]) begin vd = 2'b01; tag = "R4"; end
    else if (stateen_present && virt_mode && sc && !hstateen0[57]) begin vd = 2'b10; tag = "R5"; end
    else begin
      if (cur_priv == 2'd3) tag = "R9";
      else if (!stateen_present) tag = "R7";
      else if (hc) tag = "R6";
      else tag = "R8";
      if (cur_priv == 2'd3) vd = 2'b00;
      else if (csr_addr[9:8] == 2'd3) vd = 2'b01;
      else if (csr_addr[9:8] == 2'd2) vd = virt_mode ? 2'b10 : (cur_priv == 2'd1 ? 2'b00 : 2'b01);
      else if (csr_addr[9:8] == 2'd1) vd = (cur_priv != 2'd0) ? 2'b00 : (virt_mode ? 2'b10 : 2'b01);
      else vd = 2'b00;
    end
  endtask

  task automatic compare();
    logic [1:0] ev;
    logic [31:0] em;
    string tag;
    model(ev, em, tag);
    checks++;
    if (verdict !== ev) begin
      failures++;
      $display("FAIL %s verdict addr=%h priv=%0d v=%0b: actual=%b expected=%b",
               (verdict === 2'b11) ? "R1" : tag, csr_addr, cur_priv, virt_mode, verdict, ev);
    end
    checks++;
    if (impl_mask !== em) begin
      failures++;
      $display("FAIL R10 mask addr=%h: actual=%h expected=%h", csr_addr, impl_mask, em);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [6];
    addrs = '{12'h5A8, 12'h6A8, 12'h612, 12'h300, 12'h100, 12'h000};
    csr_addr = 12'h0; cur_priv = 2'd0; virt_mode = 0; xlen_is32 = 0;
    hyp_ext = 0; stateen_present = 0; mstateen0 = '0; hstateen0 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare(); // reset state: address 0 from U allowed, mask zero (R8, R10)
    for (int a = 0; a < 6; a++)
      for (int p = 0; p < 4; p++)
        for (int k = 0; k < 128; k++) begin
          if (p == 2) continue;
          if (p == 3 && k[0]) continue;
          @(posedge clk);
          csr_addr = addrs[a];
          cur_priv = 2'(p);
          virt_mode = k[0];
          xlen_is32 = k[1];
          hyp_ext = k[2];
          stateen_present = k[3];
          mstateen0 = 64'h0;
          hstateen0 = 64'hFFFF_FFFF_FFFF_FFFF;
          mstateen0[56] = k[4];
          mstateen0[57] = k[5];
          hstateen0[57] = k[6];
          @(negedge clk);
          compare();
        end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule